// File: doc/BRIEF.md
# Shift/Ring Dataset Register

This block is a buffer of up to fifty datasets, each one a signed 32-bit word together with eight flag bits. Separate write and read strobes move data in. In ring mode it works as a circular queue whose write and read positions move independently. In shift mode it works as a delay line whose length is the configured depth plus one. A direction input reverses the order in which positions are visited. A correction strobe subtracts a signed value from every word in use, and the result saturates. A full reset clears data, flags and positions. A lighter pointer reset returns only the two positions to zero.

On the output side the block always presents the dataset at the current read position. An enable input chooses between that dataset's word and a substitute word. The flags are always shown, so bit 0 can be wired back to the enable outside the block and act as a data-valid mark chosen when the dataset is written. Status outputs report full, overflow, zero depth and the current distance between the write and read positions. Acknowledge pulses follow each reset and each correction. Every input is sampled on one system clock.

Top module: `dset_shift_ring`

## Requirements
- R1: The number of datasets in use is N = `depth_sel` + 1. Any `depth_sel` above 49 is treated as 49, and `act_depth` never exceeds 49.
- R2: In ring mode with `dir_rev`=0, a write stores at the write position, and a read moves the read position on, so words come out in write order. Both positions step +1 and wrap from N-1 to 0. `act_depth` is (write position - read position) mod N.
- R3: With `dir_rev`=1, the positions step -1 and wrap from 0 to N-1. In ring mode `act_depth` becomes (read position - write position) mod N. In shift mode the output is taken from slot 0 instead of slot N-1.
- R4: In shift mode with `dir_rev`=0, a write puts the new dataset in slot 0 and moves slot k into slot k+1, for k below N-1. With `dir_rev`=1, the new dataset goes into slot N-1 and slot k+1 moves into slot k. Read strobes change nothing. `act_depth` reads N-1.
- R5: A change of `mode_ring` or `depth_sel` between two clock cycles causes a full reset, with the same effect as `clr_all`.
- R6: A full reset (`clr_all` high in a cycle) clears every word and flag, both positions, `full` and `ovf`. `rst_ack` is high in the next cycle only.
- R7: A pointer reset (`clr_ptr` high) sets both positions to zero. Stored data, `full` and `ovf` keep their values, and `rst_ack` does not pulse.
- R8: A correction subtracts the signed `corr_val` from the word of each dataset in use. The result saturates to the range -2^31 to 2^31-1. `corr_ack` is high for one cycle after the correction is applied.
- R9: With `out_en`=1, `dout_word` carries the word at the read position. With `out_en`=0 it carries `subst_word`. `dout_flags` always carries the flags at the read position.
- R10: Priority runs full reset, then pointer reset, then write, then read, then correction. A reset in a cycle blocks every other command in that cycle. A correction that meets a write or a read is held pending and applied in the first cycle free of those commands.
- R11: `full` rises once N writes have been made since the last full reset. `ovf` rises at the (N+1)-th write, when data is first overwritten or shifted out. `ovf` implies `full`.
- R12: `depth_zero` is high exactly when N = 1. In that case each write replaces the only dataset.
- R13: `wr_tick`, `rd_tick` and `corr_tick` act on their rising edge only. A strobe held high for several cycles counts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_ring | input | 1 | 0 = shift, 1 = ring |
| depth_sel | input | 6 | Configured depth; datasets in use = value + 1 |
| dir_rev | input | 1 | 0 = forward, 1 = backward |
| wr_tick | input | 1 | Write strobe (edge) |
| rd_tick | input | 1 | Read strobe (edge) |
| clr_all | input | 1 | Full reset command |
| clr_ptr | input | 1 | Pointer-only reset command |
| corr_tick | input | 1 | Correction strobe (edge) |
| corr_val | input | 32 | Signed value subtracted on correction |
| din_word | input | 32 | Word to write |
| din_flags | input | 8 | Flags to write |
| out_en | input | 1 | Selects read dataset (1) or substitute (0) |
| subst_word | input | 32 | Substitute output word |
| dout_word | output | 32 | Output word |
| dout_flags | output | 8 | Flags at read position |
| full | output | 1 | Filled since last full reset |
| ovf | output | 1 | Depth traversed once |
| depth_zero | output | 1 | Only one dataset in use |
| act_depth | output | 6 | Current write/read distance |
| rst_ack | output | 1 | One-cycle pulse after full reset |
| corr_ack | output | 1 | One-cycle pulse after correction |

## Verification
The output is a combinational function of stored state, so a wrong write or read position shows in `dout_word` and `act_depth` at the first sample after the strobe that moved it. A fill counter that steps wrongly shows as `full` or `ovf` at the wrong write, one cycle after that write. A priority or pending fault shows as a shifted `corr_ack` pulse, or as a corrected value that appears one sample early or late. Direction faults stay hidden while both positions move together. For that reason the bench changes direction after a pointer reset, and in shift mode in the middle of the stream, so that the order becomes visible at the port.

// File: rtl/dset_shift_ring.sv
module dset_shift_ring #(
  parameter int DW   = 32,
  parameter int FW   = 8,
  parameter int DMAX = 50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_ring,
  input  logic [5:0]    depth_sel,
  input  logic          dir_rev,
  input  logic          wr_tick,
  input  logic          rd_tick,
  input  logic          clr_all,
  input  logic          clr_ptr,
  input  logic          corr_tick,
  input  logic [DW-1:0] corr_val,
  input  logic [DW-1:0] din_word,
  input  logic [FW-1:0] din_flags,
  input  logic          out_en,
  input  logic [DW-1:0] subst_word,
  output logic [DW-1:0] dout_word,
  output logic [FW-1:0] dout_flags,
  output logic          full,
  output logic          ovf,
  output logic          depth_zero,
  output logic [5:0]    act_depth,
  output logic          rst_ack,
  output logic          corr_ack
);
  localparam int SW = 6;
  localparam logic [SW-1:0] LAST_MAX = SW'(DMAX - 1);

  logic [DW-1:0] wm [DMAX];
  logic [FW-1:0] fm [DMAX];
  logic [DW-1:0] fw_w [DMAX];
  logic [FW-1:0] fw_f [DMAX];
  logic [DW-1:0] bw_w [DMAX];
  logic [FW-1:0] bw_f [DMAX];
  logic [DW-1:0] cr_w [DMAX];

  logic [SW-1:0] wr_idx, rd_idx, rd_pos, eff_last;
  logic [SW:0]   n_cur, fill_cnt, fwd_d, bwd_d;
  logic          wr_q, rd_q, corr_q, corr_pend, armed;
  logic          mode_q;
  logic [5:0]    depth_q;
  logic          wr_edge, rd_edge, corr_edge, cfg_chg;
  logic          do_full, do_ptr, do_wr, do_rd, do_corr;

  function automatic logic [DW-1:0] sat_sub(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [DW:0] d;
    d = {a[DW-1], a} - {b[DW-1], b};
    if (d[DW] != d[DW-1])
      sat_sub = d[DW] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
    else
      sat_sub = d[DW-1:0];
  endfunction

  function automatic logic [SW-1:0] step_idx(input logic [SW-1:0] p, input logic back,
                                             input logic [SW-1:0] last);
    if (back) step_idx = (p == '0) ? last : p - SW'(1);
    else      step_idx = (p == last) ? '0 : p + SW'(1);
  endfunction

  assign eff_last  = (depth_sel > LAST_MAX) ? LAST_MAX : depth_sel;
  assign n_cur     = {1'b0, eff_last} + (SW+1)'(1);

  assign wr_edge   = wr_tick & ~wr_q;
  assign rd_edge   = rd_tick & ~rd_q;
  assign corr_edge = corr_tick & ~corr_q;
  assign cfg_chg   = armed & ((mode_ring != mode_q) | (depth_sel != depth_q));

  assign do_full = clr_all | cfg_chg;
  assign do_ptr  = ~do_full & clr_ptr;
  assign do_wr   = ~do_full & ~do_ptr & wr_edge;
  assign do_rd   = ~do_full & ~do_ptr & rd_edge & mode_ring;
  assign do_corr = ~do_full & ~do_ptr & ~wr_edge & ~rd_edge & (corr_edge | corr_pend);

  for (genvar g = 0; g < DMAX; g++) begin : g_slot
    if (g == 0) begin : g_head
      assign fw_w[g] = din_word;
      assign fw_f[g] = din_flags;
    end else begin : g_body
      assign fw_w[g] = wm[g-1];
      assign fw_f[g] = fm[g-1];
    end
    if (g == DMAX - 1) begin : g_tail
      assign bw_w[g] = din_word;
      assign bw_f[g] = din_flags;
    end else begin : g_mid
      assign bw_w[g] = wm[g+1];
      assign bw_f[g] = fm[g+1];
    end
    assign cr_w[g] = sat_sub(wm[g], corr_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DMAX; i++) begin
        wm[i] <= '0;
        fm[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DMAX; i++) begin
        if (do_full) begin
          wm[i] <= '0;
          fm[i] <= '0;
        end else if (do_wr) begin
          if (mode_ring) begin
            if (wr_idx == SW'(i)) begin
              wm[i] <= din_word;
              fm[i] <= din_flags;
            end
          end else if (!dir_rev) begin
            if (SW'(i) <= eff_last) begin
              wm[i] <= fw_w[i];
              fm[i] <= fw_f[i];
            end
          end else begin
            if (SW'(i) == eff_last) begin
              wm[i] <= din_word;
              fm[i] <= din_flags;
            end else if (SW'(i) < eff_last) begin
              wm[i] <= bw_w[i];
              fm[i] <= bw_f[i];
            end
          end
        end else if (do_corr) begin
          if (SW'(i) <= eff_last) wm[i] <= cr_w[i];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx    <= '0;
      rd_idx    <= '0;
      fill_cnt  <= '0;
      wr_q      <= 1'b0;
      rd_q      <= 1'b0;
      corr_q    <= 1'b0;
      corr_pend <= 1'b0;
      armed     <= 1'b0;
      mode_q    <= 1'b0;
      depth_q   <= '0;
      rst_ack   <= 1'b0;
      corr_ack  <= 1'b0;
    end else begin
      wr_q     <= wr_tick;
      rd_q     <= rd_tick;
      corr_q   <= corr_tick;
      armed    <= 1'b1;
      mode_q   <= mode_ring;
      depth_q  <= depth_sel;
      rst_ack  <= do_full;
      corr_ack <= do_corr;

      if (do_full) corr_pend <= 1'b0;
      else if (do_corr) corr_pend <= 1'b0;
      else if (corr_edge) corr_pend <= 1'b1;

      if (do_full) begin
        wr_idx   <= '0;
        rd_idx   <= '0;
        fill_cnt <= '0;
      end else if (do_ptr) begin
        wr_idx <= '0;
        rd_idx <= '0;
      end else begin
        if (do_wr) begin
          if (mode_ring) wr_idx <= step_idx(wr_idx, dir_rev, eff_last);
          if (fill_cnt <= n_cur) fill_cnt <= fill_cnt + (SW+1)'(1);
        end
        if (do_rd) rd_idx <= step_idx(rd_idx, dir_rev, eff_last);
      end
    end
  end

  assign fwd_d = (wr_idx >= rd_idx) ? ({1'b0, wr_idx} - {1'b0, rd_idx})
                                    : ({1'b0, wr_idx} + n_cur - {1'b0, rd_idx});
  assign bwd_d = (rd_idx >= wr_idx) ? ({1'b0, rd_idx} - {1'b0, wr_idx})
                                    : ({1'b0, rd_idx} + n_cur - {1'b0, wr_idx});

  assign rd_pos     = mode_ring ? rd_idx : (dir_rev ? '0 : eff_last);
  assign dout_word  = out_en ? wm[rd_pos] : subst_word;
  assign dout_flags = fm[rd_pos];
  assign full       = fill_cnt >= n_cur;
  assign ovf        = fill_cnt > n_cur;
  assign depth_zero = (eff_last == '0);
  assign act_depth  = mode_ring ? (dir_rev ? bwd_d[SW-1:0] : fwd_d[SW-1:0]) : eff_last;
endmodule

// File: rtl/dset_shift_ring_chk.sv
module dset_shift_ring_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_ring,
  input logic [5:0] depth_sel,
  input logic       clr_all,
  input logic       clr_ptr,
  input logic       full,
  input logic       ovf,
  input logic       depth_zero,
  input logic [5:0] act_depth,
  input logic       rst_ack,
  input logic       corr_ack
);
  AST_ACT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    act_depth <= 6'd49); // R1
  AST_RST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_all) |-> rst_ack); // R6
  AST_RST_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (!full && !ovf)); // R6
  AST_PTR_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ptr && !clr_all && $stable(mode_ring) && $stable(depth_sel)) |=> ($stable(full) && $stable(ovf))); // R7
  AST_ACKS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_ack && corr_ack)); // R10
  AST_OVF_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> full); // R11
  AST_ZERO_NO_DISTANCE: assert property (@(posedge clk) disable iff (!rst_n)
    depth_zero |-> (act_depth == 6'd0)); // R12
endmodule

bind dset_shift_ring dset_shift_ring_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mode_ring(mode_ring), .depth_sel(depth_sel),
  .clr_all(clr_all), .clr_ptr(clr_ptr), .full(full), .ovf(ovf),
  .depth_zero(depth_zero), .act_depth(act_depth), .rst_ack(rst_ack), .corr_ack(corr_ack)
);

// File: tb/dset_shift_ring_tb_top.sv
`timescale 1ns/1ps
module dset_shift_ring_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_ring = 1'b1, dir_rev = 1'b0;
  logic [5:0] depth_sel = 6'd2;
  logic wr_tick = 0, rd_tick = 0, clr_all = 0, clr_ptr = 0, corr_tick = 0, out_en = 1;
  logic [31:0] corr_val = '0, din_word = '0, subst_word = '0;
  logic [7:0] din_flags = '0;
  logic [31:0] dout_word;
  logic [7:0] dout_flags;
  logic full, ovf, depth_zero, rst_ack, corr_ack;
  logic [5:0] act_depth;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  dset_shift_ring dut_i (
    .clk(clk), .rst_n(rst_n), .mode_ring(mode_ring), .depth_sel(depth_sel), .dir_rev(dir_rev),
    .wr_tick(wr_tick), .rd_tick(rd_tick), .clr_all(clr_all), .clr_ptr(clr_ptr),
    .corr_tick(corr_tick), .corr_val(corr_val), .din_word(din_word), .din_flags(din_flags),
    .out_en(out_en), .subst_word(subst_word), .dout_word(dout_word), .dout_flags(dout_flags),
    .full(full), .ovf(ovf), .depth_zero(depth_zero), .act_depth(act_depth),
    .rst_ack(rst_ack), .corr_ack(corr_ack));

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] w, input logic [7:0] f);
    din_word = w; din_flags = f; wr_tick = 1; step(); wr_tick = 0; step();
  endtask

  task automatic rd();
    rd_tick = 1; step(); rd_tick = 0; step();
  endtask

  task automatic full_reset();
    clr_all = 1; step(); clr_all = 0;
    check("R6", "rst_ack", 32'(rst_ack), 1);
    step();
    check("R6", "rst_ack drop", 32'(rst_ack), 0);
  endtask

  task automatic t_reset_state();
    check("R6", "word after reset", dout_word, 0);
    check("R11", "full after reset", 32'(full), 0);
    check("R2", "distance after reset", 32'(act_depth), 0);
    check("R12", "zero with N=3", 32'(depth_zero), 0);
  endtask

  task automatic t_ring();
    wr(10, 8'h01); wr(20, 8'h03);
    check("R2", "distance 2", 32'(act_depth), 2);
    check("R2", "head word", dout_word, 10);
    check("R11", "not full", 32'(full), 0);
    wr(30, 8'h00);
    check("R11", "full at N", 32'(full), 1);
    check("R11", "no ovf at N", 32'(ovf), 0);
    check("R2", "wrapped distance", 32'(act_depth), 0);
    rd();
    check("R2", "second word", dout_word, 20);
    check("R9", "second flags", 32'(dout_flags), 32'h03);
    check("R2", "distance after read", 32'(act_depth), 2);
    wr(40, 8'hA5);
    check("R11", "ovf at N+1", 32'(ovf), 1);
    rd(); check("R2", "third word", dout_word, 30);
    rd(); check("R2", "overwritten word", dout_word, 40);
  endtask

  task automatic t_out_en();
    subst_word = 32'hDEAD; out_en = 0; step();
    check("R9", "substitute word", dout_word, 32'hDEAD);
    check("R9", "flags still shown", 32'(dout_flags), 32'hA5);
    out_en = 1; step();
    check("R9", "dataset word back", dout_word, 40);
  endtask

  task automatic t_dir();
    full_reset();
    wr(1, 0); wr(2, 0); wr(3, 0);
    clr_ptr = 1; step(); clr_ptr = 0;
    check("R7", "no rst_ack on pointer reset", 32'(rst_ack), 0);
    step();
    check("R7", "full kept", 32'(full), 1);
    check("R7", "data kept, pos 0", dout_word, 1);
    check("R7", "distance zero", 32'(act_depth), 0);
    dir_rev = 1; step();
    rd();
    check("R3", "backward wrap read", dout_word, 3);
    check("R3", "backward distance", 32'(act_depth), 2);
    rd();
    check("R3", "backward next", dout_word, 2);
    dir_rev = 0; step();
  endtask

  task automatic t_corr();
    full_reset();
    wr(100, 0); wr(32'h8000_0005, 0); wr(7, 0);
    corr_val = 10; corr_tick = 1; step(); corr_tick = 0;
    check("R8", "corr_ack", 32'(corr_ack), 1);
    step();
    check("R8", "corr_ack drop", 32'(corr_ack), 0);
    check("R8", "plain subtract", dout_word, 90);
    rd(); check("R8", "negative saturate", dout_word, 32'h8000_0000);
    rd(); check("R8", "to negative", dout_word, 32'hFFFF_FFFD);
    corr_val = 32'h8000_0000; corr_tick = 1; step(); corr_tick = 0; step();
    check("R8", "large fits", dout_word, 32'h7FFF_FFFD);
    rd(); check("R8", "positive saturate", dout_word, 32'h7FFF_FFFF);
  endtask

  task automatic t_prio();
    full_reset();
    clr_ptr = 1; din_word = 55; wr_tick = 1; step(); clr_ptr = 0; wr_tick = 0; step();
    check("R10", "write blocked by ptr reset", 32'(act_depth), 0);
    check("R10", "no fill", 32'(full), 0);
    check("R10", "slot untouched", dout_word, 0);
    corr_val = 1; din_word = 50; wr_tick = 1; corr_tick = 1; step();
    wr_tick = 0; corr_tick = 0;
    check("R10", "corr deferred", 32'(corr_ack), 0);
    check("R10", "write first", dout_word, 50);
    step();
    check("R10", "corr ack late", 32'(corr_ack), 1);
    check("R10", "written word corrected", dout_word, 49);
    step();
    clr_all = 1; din_word = 66; wr_tick = 1; step(); clr_all = 0; wr_tick = 0;
    check("R10", "reset ack", 32'(rst_ack), 1);
    step();
    check("R10", "write blocked by reset", 32'(act_depth), 0);
    check("R10", "data cleared", dout_word, 0);
  endtask

  task automatic t_edge();
    din_word = 77; din_flags = 0; wr_tick = 1; step(); step(); step(); wr_tick = 0; step();
    check("R13", "held strobe writes once", 32'(act_depth), 1);
    check("R13", "held word", dout_word, 77);
  endtask

  task automatic t_shift();
    mode_ring = 0; step();
    check("R5", "implied reset on mode", 32'(rst_ack), 1);
    step();
    check("R4", "shift distance", 32'(act_depth), 2);
    wr(5, 0); check("R4", "delay 1", dout_word, 0);
    wr(6, 0); check("R4", "delay 2", dout_word, 0);
    wr(7, 0); check("R4", "delay 3", dout_word, 5);
    wr(8, 0); check("R4", "shift out", dout_word, 6);
    check("R11", "shift ovf", 32'(ovf), 1);
    rd(); check("R4", "read no effect", dout_word, 6);
    dir_rev = 1; step();
    check("R3", "shift backward tap", dout_word, 8);
    wr(9, 0); check("R3", "backward shift", dout_word, 7);
    depth_sel = 6'd63; step();
    check("R5", "implied reset on depth", 32'(rst_ack), 1);
    step();
    check("R1", "clamped depth", 32'(act_depth), 49);
    check("R5", "data cleared", dout_word, 0);
    check("R12", "zero off", 32'(depth_zero), 0);
  endtask

  task automatic t_zero();
    dir_rev = 0; mode_ring = 1; depth_sel = 0; step(); step();
    check("R12", "zero on", 32'(depth_zero), 1);
    wr(9, 0);
    check("R12", "single full", 32'(full), 1);
    check("R12", "single word", dout_word, 9);
    wr(11, 0);
    check("R12", "replaced", dout_word, 11);
    check("R11", "single ovf", 32'(ovf), 1);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1; step();
    t_reset_state();
    t_ring();
    t_out_en();
    t_dir();
    t_corr();
    t_prio();
    t_edge();
    t_shift();
    t_zero();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule